// File: doc/BRIEF.md
# Staircase Soft-Start Reference Sequencer

This block generates the digital reference code for a switching regulator's error amplifier during startup. After enable it raises the code from zero to full scale in equal steps, so the output voltage climbs monotonically and the inrush current stays bounded. Steps are timed by counting switching-cycle strobes, not clock cycles, so the ramp stretches or shrinks with the switching frequency. With the defaults the ramp takes 2048 switching cycles, which is about 8 ms at 250 kHz and about 2 ms at 1 MHz. A full-scale code stands for the 0.6 V reference, so one step is worth roughly 9.4 mV.

An overcurrent controller can ask for a restart. The block then forces the code to zero and keeps it there for a timed hold, counted in strobes. After the hold it runs a fresh ramp from zero. A freeze input pauses the ramp where it is. The conversion of the code to a voltage happens outside this block.

Top module: `ss_ref_seq`

## Requirements
- R1: While reset is asserted, and on the first clock after reset, `ref_code` is 0 and both `ss_active` and `ss_done` are low.
- R2: With `en` high and the block idle, `ss_active` rises on the next clock while `ref_code` stays 0. After that, `ref_code` goes up by one on the clock of every CYC_PER_STEP-th counted strobe (default 32). It reaches the full-scale value STEPS (default 64) after STEPS*CYC_PER_STEP strobes (default 2048).
- R3: With `en` high and no restart request, `ref_code` changes only on a clock in which `sw_tick` is high. It then either stays the same or rises by exactly one.
- R4: `ref_code` never exceeds STEPS. On the clock where it reaches STEPS, `ss_active` falls and `ss_done` rises. `ss_done` then stays high, with the code at STEPS, until a restart or a disable.
- R5: `ss_active` and `ss_done` are never high at the same time.
- R6: When `en` is low, the next clock gives `ref_code` 0 and clears both flags, whatever the other inputs are. Strobes have no effect while `en` is low. `en` low takes priority over a restart request.
- R7: A restart request with `en` high makes `ref_code` 0 and clears both flags on the next clock. The block then holds for HOLD_CYCLES strobes (default 2048). On the clock of the last hold strobe, `ss_active` rises with the code still 0, and a ramp follows as in R2. A request made during the hold starts the hold count again.
- R8: During a ramp, a strobe that arrives while `freeze` is high is not counted and leaves `ref_code` unchanged. `freeze` has no effect on the hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_tick | input | 1 | One-clock strobe, once per switching cycle |
| en | input | 1 | Enable; low forces idle |
| restart_req | input | 1 | Request for a zero-hold followed by a fresh ramp |
| freeze | input | 1 | Pauses the ramp step counter |
| ref_code | output | $clog2(STEPS+1) | Reference code, 0 to STEPS |
| ss_active | output | 1 | High while the ramp is in progress |
| ss_done | output | 1 | High once full scale has been reached |

## Verification
The hardest situations to set up are a restart that arrives partway through a hold and a freeze that lands on the strobe which would have completed a step. In both, the counter that the ports cannot see is at a particular interior value. The bench uses a small configuration (4 steps of 3 strobes, a 5-strobe hold). It sweeps strobe, freeze and restart patterns whose phase moves against the hidden counters, and it checks every output after every clock against counts that the bench derives arithmetically.

// File: rtl/ss_ref_pkg.sv
package ss_ref_pkg;
    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_HOLD = 2'd1,
        SS_RAMP = 2'd2,
        SS_DONE = 2'd3
    } ss_state_e;
endpackage

// File: rtl/ss_tick_counter.sv
module ss_tick_counter #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    output logic wrap
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = adv && !clear && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (adv) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: an idle counter keeps its value (freeze gates adv)
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clear) |=> $stable(cnt_q));

    // R7: a cleared counter restarts from zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/ss_ref_seq.sv
module ss_ref_seq #(
    parameter int STEPS        = 64,
    parameter int CYC_PER_STEP = 32,
    parameter int HOLD_CYCLES  = 2048
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sw_tick,
    input  logic                           en,
    input  logic                           restart_req,
    input  logic                           freeze,
    output logic [$clog2(STEPS+1)-1:0]     ref_code,
    output logic                           ss_active,
    output logic                           ss_done
);
    import ss_ref_pkg::*;

    localparam int CODE_W = $clog2(STEPS + 1);
    localparam logic [CODE_W-1:0] FULL_CODE = CODE_W'(STEPS);

    typedef struct packed {
        ss_state_e         state;
        logic [CODE_W-1:0] code;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ramp_adv, hold_adv, step_clr, hold_clr;
    logic step_wrap, hold_wrap;

    assign ramp_adv = en && !restart_req && (seq_q.state == SS_RAMP) && sw_tick && !freeze;
    assign hold_adv = en && !restart_req && (seq_q.state == SS_HOLD) && sw_tick;
    assign step_clr = (seq_q.state != SS_RAMP);
    assign hold_clr = (seq_q.state != SS_HOLD) || restart_req;

    ss_tick_counter #(.LIMIT(CYC_PER_STEP)) u_step_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (step_clr),
        .adv   (ramp_adv),
        .wrap  (step_wrap)
    );

    ss_tick_counter #(.LIMIT(HOLD_CYCLES)) u_hold_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hold_clr),
        .adv   (hold_adv),
        .wrap  (hold_wrap)
    );

    always_comb begin
        seq_d = seq_q;
        if (!en) begin
            seq_d.state = SS_IDLE;
            seq_d.code  = '0;
        end else if (restart_req) begin
            seq_d.state = SS_HOLD;
            seq_d.code  = '0;
        end else begin
            unique case (seq_q.state)
                SS_IDLE: begin
                    seq_d.state = SS_RAMP;
                    seq_d.code  = '0;
                end
                SS_HOLD: begin
                    if (hold_wrap) seq_d.state = SS_RAMP;
                end
                SS_RAMP: begin
                    if (step_wrap) begin
                        seq_d.code = seq_q.code + CODE_W'(1);
                        if (seq_q.code + CODE_W'(1) == FULL_CODE) seq_d.state = SS_DONE;
                    end
                end
                SS_DONE: begin
                    seq_d.code = FULL_CODE;
                end
                default: seq_d = seq_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SS_IDLE;
            seq_q.code  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ref_code  = seq_q.code;
    assign ss_active = (seq_q.state == SS_RAMP);
    assign ss_done   = (seq_q.state == SS_DONE);

    // R3: without a strobe the code holds
    a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart_req && !sw_tick) |=> $stable(ref_code));

    // R3: the code moves by at most one step up
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart_req) |=>
            ((ref_code == $past(ref_code)) || (ref_code == $past(ref_code) + CODE_W'(1))));

    // R4: no overshoot, and done means full scale
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code <= FULL_CODE);
    a_r4_done_full: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ref_code == FULL_CODE));

    // R5: flags exclusive
    a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ss_active && ss_done));

    // R6: disable clears
    a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ref_code == '0 && !ss_active && !ss_done));

    // R7: restart forces zero with flags low
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart_req) |=> (ref_code == '0 && !ss_active && !ss_done));

    // R8: freeze keeps the code during a ramp
    a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart_req && freeze && ss_active) |=> $stable(ref_code));
endmodule

// File: tb/ss_ref_seq_bench.sv
`timescale 1ns/1ps
module ss_ref_seq_bench;
    localparam int S = 4;
    localparam int C = 3;
    localparam int H = 5;
    localparam int CW = $clog2(S + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_tick = 1'b0, en = 1'b0, restart_req = 1'b0, freeze = 1'b0;
    logic [CW-1:0] ref_code;
    logic ss_active, ss_done;

    int n_tests = 0;
    int n_fail  = 0;

    // bench-side expectation: phase 0 idle, 1 hold, 2 ramp/done
    int ph = 0;
    int ramp_n = 0;
    int hold_n = 0;

    always #2.5 clk = ~clk;

    ss_ref_seq #(.STEPS(S), .CYC_PER_STEP(C), .HOLD_CYCLES(H)) u_ss_ref_seq (
        .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .en(en),
        .restart_req(restart_req), .freeze(freeze),
        .ref_code(ref_code), .ss_active(ss_active), .ss_done(ss_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        int ec, ea, ed;
        ec = (ph == 2) ? ((ramp_n / C > S) ? S : ramp_n / C) : 0;
        ea = (ph == 2 && ramp_n < S * C) ? 1 : 0;
        ed = (ph == 2 && ramp_n >= S * C) ? 1 : 0;
        check({tag, " code"}, int'(ref_code), ec);
        check({tag, " active"}, int'(ss_active), ea);
        check({tag, " done"}, int'(ss_done), ed);
        check("R5 flags exclusive", int'(ss_active && ss_done), 0);
    endtask

    // apply inputs for one clock, update expectation, check outputs
    task automatic step(input logic e, input logic t, input logic f, input logic r,
                        input string tag);
        en = e; sw_tick = t; freeze = f; restart_req = r;
        @(posedge clk);
        #1;
        if (!e) begin
            ph = 0; ramp_n = 0; hold_n = 0;
        end else if (r) begin
            ph = 1; hold_n = 0; ramp_n = 0;
        end else if (ph == 0) begin
            ph = 2; ramp_n = 0;
        end else if (ph == 1) begin
            if (t) hold_n++;
            if (hold_n == H) begin ph = 2; ramp_n = 0; end
        end else begin
            if (t && !f && ramp_n < S * C) ramp_n++;
        end
        check_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1 after reset");

        // R6: strobes while disabled do nothing
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R6 disabled tick");

        // R2, R3, R4: full ramp with gaps between strobes
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2 enable");
        for (int i = 0; i < 4 * S * C + 6; i++)
            step(1'b1, (i % 4) != 3, 1'b0, 1'b0, "R2/R3/R4 ramp");

        // R6: disable from done, restart priority lost to disable
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6 disable over restart");

        // R8: freeze pattern sweeps against step phase
        for (int k = 1; k <= 3; k++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0, "R6 idle");
            step(1'b1, 1'b0, 1'b0, 1'b0, "R2 enable");
            for (int i = 0; i < 3 * S * C + 3; i++)
                step(1'b1, 1'b1, (i % (k + 1)) == k, 1'b0, "R8 freeze sweep");
        end

        // R7: restart from done, restart again inside hold, freeze ignored in hold
        step(1'b1, 1'b0, 1'b0, 1'b1, "R7 restart from done");
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b1, i[0], 1'b0, "R7/R8 hold with freeze");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R7 restart in hold");
        for (int i = 0; i < H + 2; i++)
            step(1'b1, (i % 3) != 2, 1'b1 & i[0], 1'b0, "R7 hold count");
        for (int i = 0; i < S * C + 3; i++)
            step(1'b1, 1'b1, 1'b0, 1'b0, "R7 ramp after hold");

        // R7: restart at every phase of a ramp step
        for (int p = 0; p < C + 1; p++) begin
            step(1'b1, 1'b0, 1'b0, 1'b1, "R7 restart");
            for (int i = 0; i < H; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R7 hold");
            for (int i = 0; i < C + p; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R2 partial ramp");
            step(1'b1, 1'b1, 1'b0, 1'b1, "R7 restart mid ramp");
            step(1'b0, 1'b1, 1'b0, 1'b0, "R6 disable mid hold");
            step(1'b1, 1'b0, 1'b0, 1'b0, "R2 re-enable");
            for (int i = 0; i < C + 1; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R2 ramp");
            step(1'b0, 1'b0, 1'b0, 1'b0, "R6 disable mid ramp");
            step(1'b1, 1'b0, 1'b0, 1'b0, "R2 enable");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule